// File: doc/BRIEF.md
# Supervisor Environment Control Register

This block holds the supervisor-level environment control word. It sits on the core's CSR access port and answers only at its own CSR address. It accepts full writes, set-bits and clear-bits operations, and refuses any access made with less than supervisor privilege. Values that land in reserved bit positions are discarded. A reserved encoding in the two-bit invalidate-mode field is never stored.

Beside the CSR port, the block turns its stored bits into a decision for each cache-block maintenance instruction issued by user code. The instruction kinds are zero, clean, flush and invalidate. For each one the block reports whether to trap, run natively, run an invalidate as a flush, or run it as a true invalidate. A single exported bit tells the memory-ordering logic whether fences on I/O must also order main memory. The CSR port responses and the decode are combinational from the stored state. Writes take effect at the next clock edge.

Top module: `supv_env_ctrl`

## Requirements
- R1: The register responds only when `csr_addr` equals 12'h10A. At any other address the stored value never changes, `csr_rdata` is 0 and `csr_illegal` is 0.
- R2: Privilege is encoded 0 = user, 1 = supervisor, 3 = machine. A read or write at the register's address with `cur_priv` = 0 raises `csr_illegal` in the same cycle, returns `csr_rdata` = 0 and leaves the stored value unchanged. Privilege 1 or 3 is accepted.
- R3: Bit 0 is the fence-ordering bit. It is readable and writable, and `fence_io_mem` shows its stored value.
- R4: Bit 7 enables the zero instruction. For user code (`cbo_kind` = 0), `cbo_outcome` is 1 (trap) when bit 7 is 0 and 0 (native) when bit 7 is 1.
- R5: Bit 6 enables the clean (`cbo_kind` = 1) and flush (`cbo_kind` = 2) instructions. For user code the outcome is trap (1) when bit 6 is 0 and native (0) when bit 6 is 1.
- R6: Bits 5:4 control the invalidate instruction (`cbo_kind` = 3) for user code. Value 0 gives trap (1), value 1 gives run-as-flush (2), and value 3 gives run-as-invalidate (3).
- R7: Bits 63:8 and 3:1 always read as 0, and writes to them have no effect.
- R8: `csr_op` selects the write kind: 0 replaces the word, 1 sets the bits that are 1 in `csr_wdata`, 2 clears the bits that are 1 in `csr_wdata`, and 3 leaves the register unchanged.
- R9: A write whose result would put 2 into bits 5:4 keeps the previous value of that field. The other fields in the same write still update.
- R10: After reset every implemented bit is 0. All user-mode cache-block instructions then trap and `fence_io_mem` is 0.
- R11: With `cur_priv` of 1 or 3, `cbo_outcome` is 0 (native) for every instruction kind, whatever is stored.
- R12: A read in the same cycle as a write returns the value held before the write. The new value is readable, and drives `fence_io_mem` and `cbo_outcome`, from the next cycle onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears the register |
| csr_addr | input | 12 | CSR address of the current access |
| csr_we | input | 1 | Write request |
| csr_re | input | 1 | Read request |
| csr_op | input | 2 | Write kind: 0 replace, 1 set, 2 clear, 3 none |
| csr_wdata | input | 64 | Write data or bit mask |
| cur_priv | input | 2 | Current privilege mode |
| csr_rdata | output | 64 | Read data, combinational |
| csr_illegal | output | 1 | Illegal-access indication, combinational |
| fence_io_mem | output | 1 | Fence on I/O also orders main memory |
| cbo_kind | input | 2 | Cache-block instruction: 0 zero, 1 clean, 2 flush, 3 invalidate |
| cbo_outcome | output | 2 | 0 native, 1 trap, 2 run as flush, 3 run as invalidate |

## Verification
The read data, the illegal flag and the cache-block outcome depend on the inputs of the same cycle. The bench therefore checks them one time unit after it drives the inputs on the falling edge, before the next rising edge. A write changes the register at the next rising edge. The bench model applies that write only after the same-cycle checks, so the cycle of the write checks the old value and every later access checks the new one. The random accesses mix addresses, privileges, operations and instruction kinds, and every one of them is checked on this one-cycle schedule.

// File: rtl/supv_env_pkg.sv
package supv_env_pkg;

    typedef enum logic [1:0] {
        PRIV_U    = 2'd0,
        PRIV_S    = 2'd1,
        PRIV_RSVD = 2'd2,
        PRIV_M    = 2'd3
    } priv_e;

    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_SET   = 2'd1,
        OP_CLEAR = 2'd2,
        OP_NONE  = 2'd3
    } csr_op_e;

    typedef enum logic [1:0] {
        CBO_ZERO  = 2'd0,
        CBO_CLEAN = 2'd1,
        CBO_FLUSH = 2'd2,
        CBO_INVAL = 2'd3
    } cbo_kind_e;

    typedef enum logic [1:0] {
        OUT_NATIVE   = 2'd0,
        OUT_TRAP     = 2'd1,
        OUT_AS_FLUSH = 2'd2,
        OUT_AS_INVAL = 2'd3
    } cbo_out_e;

    localparam int BIT_FENCE  = 0;
    localparam int BIT_INV_LO = 4;
    localparam int BIT_CLNFL  = 6;
    localparam int BIT_ZERO   = 7;

    localparam logic [1:0] INV_TRAP  = 2'd0;
    localparam logic [1:0] INV_FLUSH = 2'd1;
    localparam logic [1:0] INV_RSVD  = 2'd2;
    localparam logic [1:0] INV_FULL  = 2'd3;

    typedef struct packed {
        logic       zero_en;
        logic       clnflush_en;
        logic [1:0] inval_mode;
        logic       fence_mem;
    } cfg_t;

endpackage

// File: rtl/supv_env_access.sv
module supv_env_access
    import supv_env_pkg::*;
#(
    parameter int              XLEN     = 64,
    parameter int              ADDR_W   = 12,
    parameter logic [ADDR_W-1:0] CSR_ADDR = 12'h10A
) (
    input  logic [ADDR_W-1:0] csr_addr,
    input  logic              csr_we,
    input  logic              csr_re,
    input  logic [1:0]        csr_op,
    input  logic [XLEN-1:0]   csr_wdata,
    input  logic [1:0]        cur_priv,
    input  cfg_t              cfg_q,
    output logic              wr_commit,
    output cfg_t              cfg_wr,
    output logic [XLEN-1:0]   csr_rdata,
    output logic              csr_illegal
);

    logic            hit;
    logic            priv_ok;
    logic [XLEN-1:0] cur_word;
    logic [XLEN-1:0] raw;

    always_comb begin
        hit     = (csr_addr == CSR_ADDR);
        priv_ok = (priv_e'(cur_priv) == PRIV_S) || (priv_e'(cur_priv) == PRIV_M);

        cur_word                          = '0;
        cur_word[BIT_FENCE]               = cfg_q.fence_mem;
        cur_word[BIT_INV_LO+1:BIT_INV_LO] = cfg_q.inval_mode;
        cur_word[BIT_CLNFL]               = cfg_q.clnflush_en;
        cur_word[BIT_ZERO]                = cfg_q.zero_en;

        csr_illegal = hit && (csr_we || csr_re) && !priv_ok;
        csr_rdata   = (hit && csr_re && priv_ok) ? cur_word : '0;

        unique case (csr_op_e'(csr_op))
            OP_WRITE: raw = csr_wdata;
            OP_SET:   raw = cur_word | csr_wdata;
            OP_CLEAR: raw = cur_word & ~csr_wdata;
            default:  raw = cur_word;
        endcase

        cfg_wr.fence_mem   = raw[BIT_FENCE];
        cfg_wr.clnflush_en = raw[BIT_CLNFL];
        cfg_wr.zero_en     = raw[BIT_ZERO];
        if (raw[BIT_INV_LO+1:BIT_INV_LO] == INV_RSVD) begin
            cfg_wr.inval_mode = cfg_q.inval_mode;
        end else begin
            cfg_wr.inval_mode = raw[BIT_INV_LO+1:BIT_INV_LO];
        end

        wr_commit = hit && csr_we && priv_ok && (csr_op_e'(csr_op) != OP_NONE);
    end

endmodule

// File: rtl/supv_env_decode.sv
module supv_env_decode
    import supv_env_pkg::*;
#(
    parameter int N_KIND = 4
) (
    input  cfg_t       cfg_q,
    input  logic [1:0] cur_priv,
    input  logic [1:0] cbo_kind,
    output logic [1:0] cbo_outcome
);

    logic [1:0] user_out [N_KIND];

    for (genvar k = 0; k < N_KIND; k++) begin : g_kind
        if (k == int'(CBO_ZERO)) begin : g_zero
            assign user_out[k] = cfg_q.zero_en ? OUT_NATIVE : OUT_TRAP;
        end else if (k == int'(CBO_INVAL)) begin : g_inval
            always_comb begin
                unique case (cfg_q.inval_mode)
                    INV_FLUSH: user_out[k] = OUT_AS_FLUSH;
                    INV_FULL:  user_out[k] = OUT_AS_INVAL;
                    default:   user_out[k] = OUT_TRAP;
                endcase
            end
        end else begin : g_clnfl
            assign user_out[k] = cfg_q.clnflush_en ? OUT_NATIVE : OUT_TRAP;
        end
    end

    always_comb begin
        if (priv_e'(cur_priv) == PRIV_U) begin
            cbo_outcome = user_out[cbo_kind];
        end else begin
            cbo_outcome = OUT_NATIVE;
        end
    end

endmodule

// File: rtl/supv_env_ctrl.sv
module supv_env_ctrl
    import supv_env_pkg::*;
#(
    parameter int                XLEN     = 64,
    parameter int                ADDR_W   = 12,
    parameter logic [ADDR_W-1:0] CSR_ADDR = 12'h10A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] csr_addr,
    input  logic              csr_we,
    input  logic              csr_re,
    input  logic [1:0]        csr_op,
    input  logic [XLEN-1:0]   csr_wdata,
    input  logic [1:0]        cur_priv,
    output logic [XLEN-1:0]   csr_rdata,
    output logic              csr_illegal,
    output logic              fence_io_mem,
    input  logic [1:0]        cbo_kind,
    output logic [1:0]        cbo_outcome
);

    cfg_t st_d;
    cfg_t st_q;
    cfg_t cfg_wr;
    logic wr_commit;

    supv_env_access #(
        .XLEN     (XLEN),
        .ADDR_W   (ADDR_W),
        .CSR_ADDR (CSR_ADDR)
    ) u_access (
        .csr_addr    (csr_addr),
        .csr_we      (csr_we),
        .csr_re      (csr_re),
        .csr_op      (csr_op),
        .csr_wdata   (csr_wdata),
        .cur_priv    (cur_priv),
        .cfg_q       (st_q),
        .wr_commit   (wr_commit),
        .cfg_wr      (cfg_wr),
        .csr_rdata   (csr_rdata),
        .csr_illegal (csr_illegal)
    );

    supv_env_decode #(
        .N_KIND (4)
    ) u_decode (
        .cfg_q       (st_q),
        .cur_priv    (cur_priv),
        .cbo_kind    (cbo_kind),
        .cbo_outcome (cbo_outcome)
    );

    always_comb begin
        st_d = st_q;
        if (wr_commit) begin
            st_d = cfg_wr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fence_io_mem = st_q.fence_mem;

endmodule

// File: rtl/supv_env_chk.sv
module supv_env_chk
    import supv_env_pkg::*;
#(
    parameter int                XLEN     = 64,
    parameter int                ADDR_W   = 12,
    parameter logic [ADDR_W-1:0] CSR_ADDR = 12'h10A
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] csr_addr,
    input logic              csr_we,
    input logic              csr_re,
    input logic [1:0]        csr_op,
    input logic [XLEN-1:0]   csr_wdata,
    input logic [1:0]        cur_priv,
    input logic [XLEN-1:0]   csr_rdata,
    input logic              csr_illegal,
    input logic              fence_io_mem,
    input logic [1:0]        cbo_kind,
    input logic [1:0]        cbo_outcome,
    input cfg_t              cfg_q
);

    p_other_addr_stable_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_addr != CSR_ADDR) |=> $stable(cfg_q));

    p_other_addr_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_addr != CSR_ADDR) |-> (csr_rdata == '0 && !csr_illegal));

    p_user_illegal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_addr == CSR_ADDR && (csr_we || csr_re) && cur_priv == 2'd0) |-> csr_illegal);

    p_illegal_no_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        csr_illegal |=> $stable(cfg_q));

    p_fence_follows_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_addr == CSR_ADDR && csr_we && csr_op == 2'd0 && cur_priv == 2'd3)
        |=> (fence_io_mem == $past(csr_wdata[0])));

    p_zero_trap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_priv == 2'd0 && cbo_kind == 2'd0 && !cfg_q.zero_en) |-> (cbo_outcome == 2'd1));

    p_clnfl_trap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_priv == 2'd0 && (cbo_kind == 2'd1 || cbo_kind == 2'd2) && !cfg_q.clnflush_en)
        |-> (cbo_outcome == 2'd1));

    p_inval_not_native_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_priv == 2'd0 && cbo_kind == 2'd3) |-> (cbo_outcome != 2'd0));

    p_rsvd_read_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_rdata[XLEN-1:8] == '0 && csr_rdata[3:1] == 3'd0));

    p_no_op_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_op == 2'd3) |=> $stable(cfg_q));

    p_no_rsvd_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.inval_mode != 2'd2));

    p_reset_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cfg_q == '0));

    p_priv_native_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_priv != 2'd0) |-> (cbo_outcome == 2'd0));

endmodule

bind supv_env_ctrl supv_env_chk #(
    .XLEN     (XLEN),
    .ADDR_W   (ADDR_W),
    .CSR_ADDR (CSR_ADDR)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .csr_addr     (csr_addr),
    .csr_we       (csr_we),
    .csr_re       (csr_re),
    .csr_op       (csr_op),
    .csr_wdata    (csr_wdata),
    .cur_priv     (cur_priv),
    .csr_rdata    (csr_rdata),
    .csr_illegal  (csr_illegal),
    .fence_io_mem (fence_io_mem),
    .cbo_kind     (cbo_kind),
    .cbo_outcome  (cbo_outcome),
    .cfg_q        (st_q)
);

// File: tb/supv_env_ctrl_bench.sv
module supv_env_ctrl_bench;

    localparam time CLK_P = 4ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] csr_addr = '0;
    logic        csr_we = 1'b0;
    logic        csr_re = 1'b0;
    logic [1:0]  csr_op = '0;
    logic [63:0] csr_wdata = '0;
    logic [1:0]  cur_priv = '0;
    logic [63:0] csr_rdata;
    logic        csr_illegal;
    logic        fence_io_mem;
    logic [1:0]  cbo_kind = '0;
    logic [1:0]  cbo_outcome;

    int n_run  = 0;
    int n_fail = 0;
    logic [7:0] mdl = '0;

    always #(CLK_P/2) clk = ~clk;

    supv_env_ctrl u_supv_env_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .csr_addr     (csr_addr),
        .csr_we       (csr_we),
        .csr_re       (csr_re),
        .csr_op       (csr_op),
        .csr_wdata    (csr_wdata),
        .cur_priv     (cur_priv),
        .csr_rdata    (csr_rdata),
        .csr_illegal  (csr_illegal),
        .fence_io_mem (fence_io_mem),
        .cbo_kind     (cbo_kind),
        .cbo_outcome  (cbo_outcome)
    );

    function automatic logic [7:0] exp_next(logic [7:0] old, logic [1:0] op, logic [63:0] wd);
        logic [7:0] raw;
        if (op == 2'd3) return old;
        case (op)
            2'd0:    raw = wd[7:0];
            2'd1:    raw = old | wd[7:0];
            default: raw = old & ~wd[7:0];
        endcase
        raw = raw & 8'hF1;
        if (raw[5:4] == 2'd2) raw[5:4] = old[5:4];
        return raw;
    endfunction

    function automatic logic [1:0] exp_out(logic [7:0] m, logic [1:0] pv, logic [1:0] kd);
        if (pv != 2'd0) return 2'd0;
        case (kd)
            2'd0:    return m[7] ? 2'd0 : 2'd1;
            2'd3:    return (m[5:4] == 2'd1) ? 2'd2 : (m[5:4] == 2'd3) ? 2'd3 : 2'd1;
            default: return m[6] ? 2'd0 : 2'd1;
        endcase
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive one cycle, check same-cycle outputs, then update model as of the next edge.
    task automatic step(logic [11:0] ad, logic we, logic re, logic [1:0] op,
                        logic [63:0] wd, logic [1:0] pv, logic [1:0] kd, string tag);
        logic hit, ok;
        @(negedge clk);
        csr_addr = ad; csr_we = we; csr_re = re; csr_op = op;
        csr_wdata = wd; cur_priv = pv; cbo_kind = kd;
        #1;
        hit = (ad == 12'h10A);
        ok  = (pv == 2'd1) || (pv == 2'd3);
        chk({tag, " rdata R12"}, csr_rdata, (hit && re && ok) ? {56'b0, mdl} : 64'd0);
        chk({tag, " illegal R2"}, {63'b0, csr_illegal}, {63'b0, hit && (we || re) && !ok});
        chk({tag, " outcome R6"}, {62'b0, cbo_outcome}, {62'b0, exp_out(mdl, pv, kd)});
        chk({tag, " fence R3"}, {63'b0, fence_io_mem}, {63'b0, mdl[0]});
        if (hit && we && ok) mdl = exp_next(mdl, op, wd);
    endtask

    initial begin
        #(CLK_P * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R10: cleared after reset, every user kind traps
        step(12'h10A, 0, 1, 0, 0, 2'd3, 2'd0, "R10 reset read");
        for (int k = 0; k < 4; k++) step(12'h10A, 0, 0, 0, 0, 2'd0, 2'(k), "R10 user trap");

        // R7: write all ones, reserved bits drop; R12: same-cycle read returns old value
        step(12'h10A, 1, 1, 0, '1, 2'd1, 2'd3, "R7 R12 full write");
        step(12'h10A, 0, 1, 0, 0, 2'd1, 2'd0, "R7 readback");
        for (int k = 0; k < 4; k++) step(12'h10A, 0, 0, 0, 0, 2'd0, 2'(k), "R4 R5 R6 enabled");

        // R9: clear bit 4 from mode 3 would give 2 -> field held, bit 7 clear still applies
        step(12'h10A, 1, 0, 2'd2, 64'h90, 2'd3, 2'd3, "R9 clear to rsvd");
        step(12'h10A, 0, 1, 0, 0, 2'd3, 2'd0, "R9 readback");
        step(12'h10A, 0, 0, 0, 0, 2'd0, 2'd0, "R4 zero disabled");

        // R8: set and clear and no-op
        step(12'h10A, 1, 0, 2'd2, 64'h30, 2'd1, 2'd0, "R8 clear mode");
        step(12'h10A, 1, 0, 2'd1, 64'h10, 2'd1, 2'd0, "R8 set flush mode");
        step(12'h10A, 0, 0, 0, 0, 2'd0, 2'd3, "R6 as flush");
        step(12'h10A, 1, 0, 2'd1, 64'h20, 2'd1, 2'd3, "R9 set to full inval");
        step(12'h10A, 1, 0, 2'd3, 64'h0, 2'd1, 2'd3, "R8 no-op");
        step(12'h10A, 0, 0, 0, 0, 2'd0, 2'd3, "R6 as inval");

        // R2: user write refused; R1: other address ignored; R11: privileged native
        step(12'h10A, 1, 1, 2'd0, 64'h0, 2'd0, 2'd0, "R2 user write");
        step(12'h10B, 1, 1, 2'd0, 64'h0, 2'd3, 2'd0, "R1 other addr");
        step(12'h10A, 0, 1, 0, 0, 2'd1, 2'd0, "R1 R2 readback");
        for (int k = 0; k < 4; k++) step(12'h10A, 0, 0, 0, 0, 2'd1, 2'(k), "R11 supervisor");

        // constrained random mix
        for (int i = 0; i < 400; i++) begin
            logic [11:0] ad;
            logic [1:0]  pv;
            ad = ($urandom_range(0, 9) < 8) ? 12'h10A : 12'($urandom);
            pv = ($urandom_range(0, 9) < 7) ? 2'(($urandom_range(0, 1) * 2) + 1) : 2'd0;
            step(ad, 1'($urandom), 1'($urandom), 2'($urandom),
                 {$urandom, $urandom}, pv, 2'($urandom), "RND");
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule